// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block collects 40 request lines, 32 in a low bank and 8 in a high bank. It turns selected level changes on those lines into one-cycle interrupt pulses. Software controls each line through a 32-bit register bus. Every line has the following controls:

- an enable (unmask) bit
- an event-enable bit, which is stored only
- a rising-edge select
- a falling-edge select
- a software trigger bit
- a sticky pending flag

A pending flag is set in two ways. The first is a selected edge on an unmasked line. The second is a 0-to-1 change of the software trigger bit on an unmasked line. The flag stays set until software writes a 1 to it.

The line inputs are assumed to be synchronous to `clk` already. Edges are found by comparing each input with its value one clock earlier. A downstream interrupt collector is expected to latch the pulses. Some positions have no edge logic at all: the direct lines and the unimplemented high-bank lines. At those positions the trigger, software and pending storage is tied to zero.

Register map, in bytes, for one bank. The high bank is at base + 0x20.

| Offset | Register |
|---|---|
| 0x00 | enable |
| 0x04 | event-enable |
| 0x08 | rising select |
| 0x0C | falling select |
| 0x10 | software trigger |
| 0x14 | pending |

Top module: `edge_irq_ctrl`

## Requirements
- R1: Address bit 5 selects the bank (0 for lines 0-31, 1 for lines 32-39), and bits 4:2 select the register: 0 enable, 1 event-enable, 2 rising select, 3 falling select, 4 software trigger, 5 pending. Reads are combinational from `bus_addr`; a write takes effect at the clock edge on which `bus_wr` is high.
- R2: In the low bank, enable and event-enable hold all 32 bits. Rising and falling select keep only the bits in 0x007DFFFF, so bit 17 and bits 23-31 read 0.
- R3: In the high bank, enable and event-enable keep only bits 0-7 (0xFF). Rising and falling select keep only bits 3-6 (0x78). All other bits read 0.
- R4: Writes to positions outside the trigger mask are ignored in the software trigger and pending registers, and those bits read 0. The trigger mask is 0x007DFFFF for the low bank and 0x78 for the high bank.
- R5: A pending flag sets on a rising input edge when the enable and rising-select bits are 1, and on a falling input edge when the enable and falling-select bits are 1. With neither select set, no edge sets it.
- R6: On an enabled line, writing a software trigger bit from 0 to 1 sets the pending flag, and the trigger bit reads back 1.
- R7: On a masked line, the same software trigger write stores the trigger bit (it reads 1) but leaves the pending flag clear. Enabling the line later does not set it.
- R8: An edge that arrives while a line is masked is not remembered. Enabling the line afterwards leaves the pending flag clear and produces no pulse.
- R9: Writing 1 to a pending bit clears it and also clears the matching software trigger bit. The clear produces no output pulse.
- R10: `irq_pulse[i]` is high for exactly the first cycle in which pending flag i reads 1 after being 0, and is low otherwise.
- R11: If a qualifying edge and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R12: After reset, every register reads 0 and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| line_in | input | 40 | Request line levels, already synchronous |
| irq_pulse | output | 40 | Per-line single-cycle interrupt pulses |

## Verification
Line 0 is driven through all four edge-select settings: rising only, falling only, both, and none. Each setting is driven with both a rise and a fall, which separates the rising and falling qualification paths and confirms that the no-select case stays quiet.

The software trigger is exercised on low line 0 and on high line 35, with the line masked and unmasked. These cases separate a stored trigger bit from a pending interrupt, and show that unmasking later has no retroactive effect.

A masked edge on line 1, followed by unmasking, shows that edges are not remembered. A clear written in the same cycle as a new edge distinguishes set priority from clear priority. All-ones and reserved-pattern writes outline the storage masks of each bank.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int          DW          = 32,
  parameter int          HI_LINES    = 8,
  parameter int          AW          = 6,
  parameter logic [31:0] LO_MSK_KEEP = 32'hFFFF_FFFF,
  parameter logic [31:0] LO_TRG_KEEP = 32'h007D_FFFF,
  parameter logic [31:0] HI_MSK_KEEP = 32'h0000_00FF,
  parameter logic [31:0] HI_TRG_KEEP = 32'h0000_0078
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [DW+HI_LINES-1:0] line_in,
  output logic [DW+HI_LINES-1:0] irq_pulse
);
  localparam int NL       = DW + HI_LINES;
  localparam int BANK_BIT = 5;

  logic [1:0][DW-1:0] rd_bank, pend_bank, imr_bank, irq_bank;
  logic [2:0] reg_idx;
  logic       aligned;

  assign reg_idx = bus_addr[4:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [DW-1:0] MK = (b == 0) ? LO_MSK_KEEP[DW-1:0] : HI_MSK_KEEP[DW-1:0];
    localparam logic [DW-1:0] TK = (b == 0) ? LO_TRG_KEEP[DW-1:0] : HI_TRG_KEEP[DW-1:0];

    logic [DW-1:0] lvl;
    logic [DW-1:0] imr_q, emr_q, rsel_q, fsel_q, swt_q, pend_q, prev_q, irq_q;
    logic [DW-1:0] rise, fall, hw_set, sw_set, clr, set_all, pend_nx;
    logic          hit, w_imr, w_emr, w_rsel, w_fsel, w_swt, w_pend;

    if (b == 0) begin : g_lo
      assign lvl = line_in[DW-1:0];
    end else begin : g_hi
      assign lvl = {{(DW-HI_LINES){1'b0}}, line_in[NL-1:DW]};
    end

    assign hit    = bus_wr && aligned && (bus_addr[BANK_BIT] == 1'(b));
    assign w_imr  = hit && reg_idx == 3'd0;
    assign w_emr  = hit && reg_idx == 3'd1;
    assign w_rsel = hit && reg_idx == 3'd2;
    assign w_fsel = hit && reg_idx == 3'd3;
    assign w_swt  = hit && reg_idx == 3'd4;
    assign w_pend = hit && reg_idx == 3'd5;

    assign rise    = lvl & ~prev_q;
    assign fall    = ~lvl & prev_q;
    assign hw_set  = imr_q & TK & ((rise & rsel_q) | (fall & fsel_q));
    assign sw_set  = w_swt ? (bus_wdata & ~swt_q & imr_q & TK) : '0;
    assign clr     = w_pend ? (bus_wdata & TK) : '0;
    assign set_all = hw_set | sw_set;
    assign pend_nx = (pend_q & ~clr) | set_all;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        imr_q  <= '0;
        emr_q  <= '0;
        rsel_q <= '0;
        fsel_q <= '0;
        swt_q  <= '0;
        pend_q <= '0;
        prev_q <= '0;
        irq_q  <= '0;
      end else begin
        prev_q <= lvl;
        pend_q <= pend_nx;
        irq_q  <= pend_nx & ~pend_q;
        if (w_imr)  imr_q  <= bus_wdata & MK;
        if (w_emr)  emr_q  <= bus_wdata & MK;
        if (w_rsel) rsel_q <= bus_wdata & TK;
        if (w_fsel) fsel_q <= bus_wdata & TK;
        if (w_swt)  swt_q  <= bus_wdata & TK;
        else        swt_q  <= swt_q & ~clr;
      end
    end

    always_comb begin
      case (reg_idx)
        3'd0:    rd_bank[b] = imr_q;
        3'd1:    rd_bank[b] = emr_q;
        3'd2:    rd_bank[b] = rsel_q;
        3'd3:    rd_bank[b] = fsel_q;
        3'd4:    rd_bank[b] = swt_q;
        3'd5:    rd_bank[b] = pend_q;
        default: rd_bank[b] = '0;
      endcase
    end

    assign pend_bank[b] = pend_q;
    assign imr_bank[b]  = imr_q;
    assign irq_bank[b]  = irq_q;
  end

  assign bus_rdata = aligned ? rd_bank[bus_addr[BANK_BIT]] : '0;

  logic [NL-1:0] pend_lines, imr_lines;
  assign pend_lines = {pend_bank[1][HI_LINES-1:0], pend_bank[0]};
  assign imr_lines  = {imr_bank[1][HI_LINES-1:0], imr_bank[0]};
  assign irq_pulse  = {irq_bank[1][HI_LINES-1:0], irq_bank[0]};
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int          NL        = 40,
  parameter logic [39:0] PEND_KEEP = 40'h78_007D_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] irq,
  input logic [NL-1:0] pend,
  input logic [NL-1:0] imr
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((irq & $past(irq)) == '0));

  assert_pulse_on_new_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (((irq & ~pend) == '0) && ((irq & $past(pend)) == '0)));

  assert_no_pend_when_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((pend & ~$past(pend) & ~$past(imr)) == '0));

  assert_no_reserved_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~PEND_KEEP[NL-1:0]) == '0);

  assert_no_pulse_in_reset_R12: assert property (@(posedge clk)
    !rst_n |=> (irq == '0));
endmodule

bind edge_irq_ctrl edge_irq_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .irq  (irq_pulse),
  .pend (pend_lines),
  .imr  (imr_lines)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [39:0] line_in = '0;
  logic [39:0] irq_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [5:0] EN = 6'h00, EV = 6'h04, RS = 6'h08, FS = 6'h0C, SW = 6'h10, PD = 6'h14, HI = 6'h20;

  always #2 clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {8'h0, d}, {8'h0, exp});
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk);
    line_in[i] = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    line_in = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    for (int r = 0; r < 6; r++) begin
      rdchk("R12 low bank reg", 6'(r * 4), 32'h0);
      rdchk("R12 high bank reg", 6'(HI + r * 4), 32'h0);
    end
    chk("R12 no pulse", irq_pulse, 40'h0);
  endtask

  task automatic t_storage_masks();
    wr(EN, 32'hFFFF_FFFF);      rdchk("R2 enable all", EN, 32'hFFFF_FFFF);
    wr(EV, 32'hFFFF_FFFF);      rdchk("R2 event all", EV, 32'hFFFF_FFFF);
    wr(RS, 32'hFFFF_FFFF);      rdchk("R2 rise mask", RS, 32'h007D_FFFF);
    wr(FS, 32'hFFFF_FFFF);      rdchk("R2 fall mask", FS, 32'h007D_FFFF);
    wr(HI+EN, 32'hFFFF_FFFF);   rdchk("R3 hi enable", HI+EN, 32'h0000_00FF);
    wr(HI+EV, 32'hFFFF_FFFF);   rdchk("R3 hi event", HI+EV, 32'h0000_00FF);
    wr(HI+RS, 32'hFFFF_FFFF);   rdchk("R3 hi rise", HI+RS, 32'h0000_0078);
    wr(HI+FS, 32'hFFFF_FFFF);   rdchk("R3 hi fall", HI+FS, 32'h0000_0078);
    rdchk("R1 low rise unchanged by high write", RS, 32'h007D_FFFF);
    wr(EN, 32'h0);              rdchk("R2 enable clear", EN, 32'h0);
    wr(HI+RS, 32'h0);           rdchk("R3 hi rise clear", HI+RS, 32'h0);
    do_reset();
  endtask

  task automatic t_reserved();
    wr(RS, 32'hFF82_0000);     rdchk("R4 low rise direct", RS, 32'h0);
    wr(FS, 32'hFF82_0000);     rdchk("R4 low fall direct", FS, 32'h0);
    wr(SW, 32'hFF82_0000);     rdchk("R4 low sw direct", SW, 32'h0);
    wr(PD, 32'hFF82_0000);     rdchk("R4 low pend direct", PD, 32'h0);
    wr(HI+SW, 32'h0000_0087);  rdchk("R4 hi sw direct", HI+SW, 32'h0);
    wr(HI+PD, 32'h0000_0087);  rdchk("R4 hi pend direct", HI+PD, 32'h0);
    wr(HI+EN, 32'hFFFF_FF00);  rdchk("R3 hi enable reserved", HI+EN, 32'h0);
    wr(HI+SW, 32'hFFFF_FF00);  rdchk("R4 hi sw reserved", HI+SW, 32'h0);
    do_reset();
  endtask

  task automatic t_edges();
    wr(EN, 32'h1);
    wr(RS, 32'h1); wr(FS, 32'h0);
    set_line(0, 1'b1);
    rdchk("R5 rise-only rise", PD, 32'h1);
    chk("R10 pulse on set", {39'h0, irq_pulse[0]}, 40'h1);
    @(negedge clk);
    chk("R10 pulse one cycle", {39'h0, irq_pulse[0]}, 40'h0);
    wr(PD, 32'h1);
    rdchk("R9 clear pend", PD, 32'h0);
    chk("R9 clear no pulse", irq_pulse, 40'h0);
    set_line(0, 1'b0);
    rdchk("R5 rise-only fall", PD, 32'h0);

    wr(RS, 32'h0); wr(FS, 32'h1);
    set_line(0, 1'b1);
    rdchk("R5 fall-only rise", PD, 32'h0);
    set_line(0, 1'b0);
    rdchk("R5 fall-only fall", PD, 32'h1);
    wr(PD, 32'h1);

    wr(RS, 32'h1);
    set_line(0, 1'b1);
    rdchk("R5 both rise", PD, 32'h1);
    wr(PD, 32'h1);
    set_line(0, 1'b0);
    rdchk("R5 both fall", PD, 32'h1);
    wr(PD, 32'h1);

    wr(RS, 32'h0); wr(FS, 32'h0);
    set_line(0, 1'b1);
    rdchk("R5 none rise", PD, 32'h0);
    set_line(0, 1'b0);
    rdchk("R5 none fall", PD, 32'h0);
    chk("R5 none no pulse", irq_pulse, 40'h0);
    do_reset();
  endtask

  task automatic t_soft_unmasked();
    wr(EN, 32'h1);
    wr(SW, 32'h0);
    wr(SW, 32'h1);
    chk("R6 pulse line0", {39'h0, irq_pulse[0]}, 40'h1);
    rdchk("R6 sw reads 1", SW, 32'h1);
    rdchk("R6 pend set", PD, 32'h1);
    wr(PD, 32'h1);
    rdchk("R9 pend cleared", PD, 32'h0);
    rdchk("R9 sw cleared", SW, 32'h0);
    wr(HI+EN, 32'h8);
    wr(HI+SW, 32'h0);
    wr(HI+SW, 32'h8);
    chk("R6 pulse line35", {39'h0, irq_pulse[35]}, 40'h1);
    rdchk("R6 hi sw reads", HI+SW, 32'h8);
    rdchk("R6 hi pend", HI+PD, 32'h8);
    wr(HI+PD, 32'h8);
    rdchk("R9 hi sw cleared", HI+SW, 32'h0);
    do_reset();
  endtask

  task automatic t_soft_masked();
    wr(EN, 32'h0);
    wr(SW, 32'h0);
    wr(SW, 32'h1);
    rdchk("R7 sw stored", SW, 32'h1);
    rdchk("R7 no pend", PD, 32'h0);
    wr(EN, 32'h1);
    chk("R7 no pulse on unmask", irq_pulse, 40'h0);
    rdchk("R7 still no pend", PD, 32'h0);
    wr(HI+SW, 32'h8);
    rdchk("R7 hi sw stored", HI+SW, 32'h8);
    wr(HI+EN, 32'h8);
    rdchk("R7 hi no pend", HI+PD, 32'h0);
    do_reset();
  endtask

  task automatic t_masked_edge();
    wr(EN, 32'h0);
    wr(RS, 32'h2);
    set_line(1, 1'b1);
    rdchk("R8 masked edge no pend", PD, 32'h0);
    wr(EN, 32'h2);
    rdchk("R8 unmask no pend", PD, 32'h0);
    @(negedge clk);
    chk("R8 no pulse", irq_pulse, 40'h0);
    do_reset();
  endtask

  task automatic t_set_wins();
    wr(EN, 32'h1); wr(RS, 32'h1);
    set_line(0, 1'b1);
    set_line(0, 1'b0);
    rdchk("R11 setup pend", PD, 32'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = PD; bus_wdata = 32'h1;
    line_in[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rdchk("R11 set beats clear", PD, 32'h1);
    chk("R11 no new pulse", irq_pulse, 40'h0);
    do_reset();
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_storage_masks();
    t_reserved();
    t_edges();
    t_soft_unmasked();
    t_soft_masked();
    t_masked_edge();
    t_set_wins();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule